// File: doc/BRIEF.md
# Receive Packet Status Queue

This block keeps the per-packet status of a receive packet buffer. The MAC side marks the start of a frame and then reports each byte it writes. It closes the frame with an end strobe that carries a 4-bit result code. The block holds one status entry per packet in arrival order. The host sees the status word of the oldest packet, together with the number of data bytes of that packet it has not yet consumed. The host consumes bytes one at a time and drops the oldest packet with a discard command. The packet data itself is stored elsewhere. This block only tracks byte counts.

The head status word is live. While the oldest frame is still arriving, the word shows an in-progress marker and the running byte count. The block refuses new frames while its status storage is full, and raises a flag for that condition. A host read that finds no data sets a failure flag that stays set until a receive reset. The block emits single-cycle receive-complete and adapter-failure events for an interrupt unit.

Top module: `rxq_status_queue`

## Requirements
- R1: With no packet held, the head status word is 0x8000 and the available-byte count is 0.
- R2: A frame is accepted on a start strobe when no frame is open and fewer than DEPTH packets are held. `rxReceiving` is high from the cycle after the accepted start through the cycle in which the end strobe is given, and low from the next cycle. Bytes are counted in cycles where `rxReceiving` is high and `frmByte` is high, including the end cycle. While the head frame is open, its status word has bit 15 set, bits 14:11 zero, and bits 10:0 holding the running byte count.
- R3: One cycle after the end strobe, the head word of that frame has bit 15 clear, bits 14:11 equal to the code given with the end strobe, and bits 10:0 equal to the byte count. `rxCompleteEvt` is high for exactly that cycle. Codes 1000 to 1111 set bit 14 (error); the dribble code 0010 leaves bit 14 clear.
- R4: A frame with more than MAX_LEN bytes reports a byte count of MAX_LEN. Its code is forced to 1001 (oversize), whatever code came with its end strobe.
- R5: `statusOverrun` is high exactly while DEPTH packets are held. A start in that state is refused: no entry is made, `rxReceiving` stays low, the head status is unchanged, and the refused frame's bytes and end are ignored. The flag drops the cycle after a discard.
- R6: A discard with a completed head removes the head, and the next packet (or the empty word) appears in the next cycle. A discard on an empty queue, or on a head that is still open, has no effect.
- R7: The available-byte count equals the head byte count minus the bytes the host has read from that packet. A host read with a nonzero count lowers it by one. A discard resets the read count.
- R8: A host read while the available count is 0, including on an empty queue, sets `rxUnderrun` in the next cycle and pulses `adapterFailEvt` for that one cycle. `rxUnderrun` stays set until a receive reset.
- R9: A receive reset empties the queue, closes any open frame and clears the underrun and overrun flags. All of this takes effect in one cycle, and the status word is 0x8000 in the next cycle.
- R10: Status entries leave the queue in the order their frames started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxReset | input | 1 | Synchronous receive reset |
| frmStart | input | 1 | MAC: frame begins |
| frmByte | input | 1 | MAC: one byte written this cycle |
| frmEnd | input | 1 | MAC: frame ends this cycle |
| frmCode | input | 4 | MAC: result code for the frame, valid with frmEnd |
| hostRead | input | 1 | Host consumes one byte of the head packet |
| discardCmd | input | 1 | Host drops the head packet |
| headStatus | output | 16 | Status word of the head packet |
| availBytes | output | 11 | Unread bytes of the head packet |
| rxReceiving | output | 1 | A frame is being written |
| statusOverrun | output | 1 | Status storage is full |
| rxUnderrun | output | 1 | Sticky read-past-data failure |
| rxCompleteEvt | output | 1 | One-cycle pulse when a frame completes |
| adapterFailEvt | output | 1 | One-cycle pulse when the underrun flag sets |

## Verification
The bench keeps the default DEPTH of 8, so the full-storage case uses the real capacity. Frames of eight entries are filled, a ninth is refused, and the entries then drain in order. MAX_LEN is lowered to 24 so that a frame of about thirty bytes reaches the oversize path: the count saturates and the code is forced. A reference model runs alongside the design every cycle. The directed stimulus also reaches the corner cases: reads at zero availability, a discard against an open frame, and a receive reset in the middle of a frame.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int STAT_W = 16;
  localparam int LEN_W  = 11;
  localparam int CODE_W = 4;
  localparam logic [CODE_W-1:0] CODE_OVERSIZE = 4'b1001;

  // strobes from control to datapath
  typedef struct packed {
    logic clearAll;
    logic pushNew;
    logic addByte;
    logic finish;
    logic pop;
    logic readByte;
  } rxq_strobe_t;
endpackage

// File: rtl/rxq_datapath.sv
module rxq_datapath
  import rxq_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int MAX_LEN = 1514
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxq_strobe_t       stb,
  input  logic [CODE_W-1:0] endCode,
  output logic              full,
  output logic              empty,
  output logic              headDone,
  output logic              availZero,
  output logic [STAT_W-1:0] headStatus,
  output logic [LEN_W-1:0]  availBytes
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OCC_W = $clog2(DEPTH + 1);
  localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(MAX_LEN);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] rdPtr, wrPtr, curPtr;
  logic [OCC_W-1:0] occ;
  logic [LEN_W-1:0] readCnt;
  logic tooLong;

  logic [DEPTH-1:0][LEN_W-1:0]  entCnt;
  logic [DEPTH-1:0][CODE_W-1:0] entCode;
  logic [DEPTH-1:0]             entDone;

  logic curAtCap, longNow;
  assign curAtCap = (entCnt[curPtr] == LEN_CAP);
  assign longNow  = tooLong | (stb.addByte & curAtCap);

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  // one status entry per packet slot
  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    localparam logic [PTR_W-1:0] IDX = PTR_W'(e);
    logic [LEN_W-1:0]  cntQ;
    logic [CODE_W-1:0] codeQ;
    logic              doneQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cntQ <= '0; codeQ <= '0; doneQ <= 1'b0;
      end else if (stb.clearAll) begin
        cntQ <= '0; codeQ <= '0; doneQ <= 1'b0;
      end else if (stb.pushNew && wrPtr == IDX) begin
        cntQ <= '0; codeQ <= '0; doneQ <= 1'b0;
      end else if (curPtr == IDX) begin
        if (stb.addByte && !curAtCap) cntQ <= cntQ + 1'b1;
        if (stb.finish) begin
          doneQ <= 1'b1;
          codeQ <= longNow ? CODE_OVERSIZE : endCode;
        end
      end
    end
    assign entCnt[e]  = cntQ;
    assign entCode[e] = codeQ;
    assign entDone[e] = doneQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0; wrPtr <= '0; curPtr <= '0; occ <= '0; readCnt <= '0; tooLong <= 1'b0;
    end else if (stb.clearAll) begin
      rdPtr <= '0; wrPtr <= '0; curPtr <= '0; occ <= '0; readCnt <= '0; tooLong <= 1'b0;
    end else begin
      if (stb.pushNew) begin
        wrPtr   <= nextPtr(wrPtr);
        curPtr  <= wrPtr;
        tooLong <= 1'b0;
      end else if (stb.addByte && curAtCap) begin
        tooLong <= 1'b1;
      end
      if (stb.pop) begin
        rdPtr   <= nextPtr(rdPtr);
        readCnt <= '0;
      end else if (stb.readByte) begin
        readCnt <= readCnt + 1'b1;
      end
      occ <= occ + OCC_W'(stb.pushNew) - OCC_W'(stb.pop);
    end
  end

  logic [LEN_W-1:0] headCnt;
  assign headCnt    = entCnt[rdPtr];
  assign full       = (occ == OCC_W'(DEPTH));
  assign empty      = (occ == '0);
  assign headDone   = !empty && entDone[rdPtr];
  assign availBytes = empty ? '0 : headCnt - readCnt;
  assign availZero  = (availBytes == '0);

  always_comb begin
    if (empty)         headStatus = {1'b1, {(STAT_W-1){1'b0}}};
    else if (headDone) headStatus = {1'b0, entCode[rdPtr], headCnt};
    else               headStatus = {1'b1, {CODE_W{1'b0}}, headCnt};
  end

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    occ <= OCC_W'(DEPTH)); // R5
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    full && !stb.pop && !stb.clearAll |=> full); // R5
  AST_POP_COMPLETED: assert property (@(posedge clk) disable iff (!rstN)
    stb.pop |-> headDone); // R6
  AST_READ_HAS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    stb.readByte |-> !availZero); // R7
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    stb.clearAll |=> empty && headStatus == 16'h8000); // R9
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxReset,
  input  logic        frmStart,
  input  logic        frmByte,
  input  logic        frmEnd,
  input  logic        hostRead,
  input  logic        discardCmd,
  input  logic        full,
  input  logic        empty,
  input  logic        headDone,
  input  logic        availZero,
  output rxq_strobe_t stb,
  output logic        receiving,
  output logic        underrun,
  output logic        rxCompleteEvt,
  output logic        adapterFailEvt
);
  logic underrunHit;

  always_comb begin
    stb          = '0;
    stb.clearAll = rxReset;
    stb.pushNew  = frmStart && !receiving && !full;
    stb.addByte  = receiving && frmByte;
    stb.finish   = receiving && frmEnd;
    stb.pop      = discardCmd && !empty && headDone;
    stb.readByte = hostRead && !availZero;
    underrunHit  = hostRead && availZero;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      receiving <= 1'b0; underrun <= 1'b0; rxCompleteEvt <= 1'b0; adapterFailEvt <= 1'b0;
    end else if (rxReset) begin
      receiving <= 1'b0; underrun <= 1'b0; rxCompleteEvt <= 1'b0; adapterFailEvt <= 1'b0;
    end else begin
      if (stb.pushNew)     receiving <= 1'b1;
      else if (stb.finish) receiving <= 1'b0;
      rxCompleteEvt  <= stb.finish;
      adapterFailEvt <= underrunHit && !underrun;
      if (underrunHit) underrun <= 1'b1;
    end
  end

  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    underrun && !rxReset |=> underrun); // R8
  AST_FAIL_ON_UNDERRUN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(underrun) |-> adapterFailEvt); // R8
  AST_END_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    receiving && frmEnd && !rxReset |=> !receiving && rxCompleteEvt); // R3
  AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (!rstN)
    full && !receiving && !rxReset |=> !receiving); // R5
endmodule

// File: rtl/rxq_status_queue.sv
module rxq_status_queue
  import rxq_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int MAX_LEN = 1514
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxReset,
  input  logic        frmStart,
  input  logic        frmByte,
  input  logic        frmEnd,
  input  logic [3:0]  frmCode,
  input  logic        hostRead,
  input  logic        discardCmd,
  output logic [15:0] headStatus,
  output logic [10:0] availBytes,
  output logic        rxReceiving,
  output logic        statusOverrun,
  output logic        rxUnderrun,
  output logic        rxCompleteEvt,
  output logic        adapterFailEvt
);
  rxq_strobe_t stb;
  logic full, empty, headDone, availZero;

  rxq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rxReset(rxReset),
    .frmStart(frmStart), .frmByte(frmByte), .frmEnd(frmEnd),
    .hostRead(hostRead), .discardCmd(discardCmd),
    .full(full), .empty(empty), .headDone(headDone), .availZero(availZero),
    .stb(stb), .receiving(rxReceiving), .underrun(rxUnderrun),
    .rxCompleteEvt(rxCompleteEvt), .adapterFailEvt(adapterFailEvt)
  );

  rxq_datapath #(.DEPTH(DEPTH), .MAX_LEN(MAX_LEN)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .endCode(frmCode),
    .full(full), .empty(empty), .headDone(headDone), .availZero(availZero),
    .headStatus(headStatus), .availBytes(availBytes)
  );

  assign statusOverrun = full;
endmodule

// File: tb/rxq_status_queue_bench.sv
module rxq_status_queue_bench;
  localparam int DEPTH   = 8;
  localparam int MAX_LEN = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxReset = 0, frmStart = 0, frmByte = 0, frmEnd = 0, hostRead = 0, discardCmd = 0;
  logic [3:0]  frmCode = '0;
  logic [15:0] headStatus;
  logic [10:0] availBytes;
  logic rxReceiving, statusOverrun, rxUnderrun, rxCompleteEvt, adapterFailEvt;

  always #2 clk = ~clk;

  rxq_status_queue #(.DEPTH(DEPTH), .MAX_LEN(MAX_LEN)) u_rxq_status_queue (
    .clk(clk), .rstN(rstN), .rxReset(rxReset),
    .frmStart(frmStart), .frmByte(frmByte), .frmEnd(frmEnd), .frmCode(frmCode),
    .hostRead(hostRead), .discardCmd(discardCmd),
    .headStatus(headStatus), .availBytes(availBytes), .rxReceiving(rxReceiving),
    .statusOverrun(statusOverrun), .rxUnderrun(rxUnderrun),
    .rxCompleteEvt(rxCompleteEvt), .adapterFailEvt(adapterFailEvt)
  );

  int errors = 0, checks = 0;
  bit finished = 0;
  string phase = "R1";

  // reference model
  int qCnt[$], qCode[$], qDone[$];
  int mRead = 0;
  bit mRecv = 0, mLong = 0, mUnder = 0, mCompl = 0, mFail = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] expStatus();
    if (qCnt.size() == 0) return 16'h8000;
    if (qDone[0] == 0) return {1'b1, 4'b0, 11'(qCnt[0])};
    return {1'b0, 4'(qCode[0]), 11'(qCnt[0])};
  endfunction

  task automatic modelStep();
    int avail, last;
    bit headDn, popOk, rdOk, under, startOk, byteOk, endOk;
    if (rxReset) begin
      qCnt.delete(); qCode.delete(); qDone.delete();
      mRead = 0; mRecv = 0; mLong = 0; mUnder = 0; mCompl = 0; mFail = 0;
      return;
    end
    headDn  = qCnt.size() != 0 && qDone[0] == 1;
    avail   = (qCnt.size() == 0) ? 0 : qCnt[0] - mRead;
    popOk   = discardCmd && headDn;
    rdOk    = hostRead && avail > 0;
    under   = hostRead && avail == 0;
    startOk = frmStart && !mRecv && qCnt.size() < DEPTH;
    byteOk  = mRecv && frmByte;
    endOk   = mRecv && frmEnd;
    mFail   = under && !mUnder;
    if (under) mUnder = 1;
    mCompl  = endOk;
    last = qCnt.size() - 1;
    if (byteOk) begin
      if (qCnt[last] == MAX_LEN) mLong = 1; else qCnt[last]++;
    end
    if (endOk) begin
      qDone[last] = 1;
      qCode[last] = mLong ? 9 : int'(frmCode);
      mRecv = 0;
    end
    if (rdOk) mRead++;
    if (popOk) begin
      void'(qCnt.pop_front()); void'(qCode.pop_front()); void'(qDone.pop_front());
      mRead = 0;
    end
    if (startOk) begin
      qCnt.push_back(0); qCode.push_back(0); qDone.push_back(0);
      mRecv = 1; mLong = 0;
    end
  endtask

  task automatic compareAll();
    chk(phase, "headStatus", headStatus, expStatus());
    chk(phase, "availBytes", availBytes, (qCnt.size() == 0) ? 0 : qCnt[0] - mRead);
    chk(phase, "rxReceiving", rxReceiving, mRecv);
    chk(phase, "statusOverrun", statusOverrun, qCnt.size() == DEPTH);
    chk(phase, "rxUnderrun", rxUnderrun, mUnder);
    chk(phase, "rxCompleteEvt", rxCompleteEvt, mCompl);
    chk(phase, "adapterFailEvt", adapterFailEvt, mFail);
  endtask

  task automatic cyc();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareAll();
  endtask

  task automatic idle();
    frmStart = 0; frmByte = 0; frmEnd = 0; hostRead = 0; discardCmd = 0; rxReset = 0;
  endtask

  // start, n byte cycles with end on the last one
  task automatic frame(int n, logic [3:0] code);
    frmStart = 1; cyc(); frmStart = 0;
    for (int i = 0; i < n; i++) begin
      frmByte = 1;
      if (i == n - 1) begin frmEnd = 1; frmCode = code; end
      cyc();
    end
    idle();
  endtask

  task automatic discard();
    discardCmd = 1; cyc(); discardCmd = 0;
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1: reset state
    phase = "R1";
    compareAll();
    chk("R1", "empty word", headStatus, 16'h8000);
    chk("R1", "empty avail", availBytes, 0);

    // R8: read with nothing held
    phase = "R8";
    hostRead = 1; cyc(); hostRead = 0;
    chk("R8", "underrun set", rxUnderrun, 1);
    chk("R8", "fail pulse", adapterFailEvt, 1);
    repeat (3) cyc();
    chk("R8", "underrun sticky", rxUnderrun, 1);
    chk("R8", "fail one cycle", adapterFailEvt, 0);

    // R9: receive reset clears flag
    phase = "R9";
    rxReset = 1; cyc(); rxReset = 0;
    chk("R9", "underrun cleared", rxUnderrun, 0);

    // R2: live count during frame
    phase = "R2";
    frmStart = 1; frmByte = 1; cyc(); frmStart = 0;
    chk("R2", "receiving", rxReceiving, 1);
    chk("R2", "start-cycle byte ignored", headStatus, 16'h8000);
    cyc(); cyc(); cyc();
    chk("R2", "running word", headStatus, 16'h8003);
    // R3: end with plain code
    phase = "R3";
    frmEnd = 1; frmCode = 4'b0000; cyc(); idle();
    chk("R3", "done word", headStatus, 16'h0004);
    chk("R3", "complete pulse", rxCompleteEvt, 1);
    chk("R3", "receiving low", rxReceiving, 0);
    cyc();
    chk("R3", "complete one cycle", rxCompleteEvt, 0);

    // R7: consume bytes
    phase = "R7";
    hostRead = 1; cyc(); cyc(); cyc(); hostRead = 0;
    chk("R7", "avail after 3 reads", availBytes, 1);
    hostRead = 1; cyc(); hostRead = 0;
    chk("R7", "avail zero", availBytes, 0);
    // R8: read past packet data
    phase = "R8";
    hostRead = 1; cyc(); hostRead = 0;
    chk("R8", "underrun at end", rxUnderrun, 1);
    phase = "R6";
    discard();
    chk("R6", "queue empty", headStatus, 16'h8000);
    discard();
    chk("R6", "discard on empty", headStatus, 16'h8000);
    phase = "R9";
    rxReset = 1; cyc(); idle();

    // R3: error codes
    phase = "R3";
    frame(4, 4'b1101);
    chk("R3", "crc word", headStatus, 16'h6804);
    discard();
    frame(6, 4'b0010);
    chk("R3", "dribble word", headStatus, 16'h1006);
    discard();

    // R4: oversize
    phase = "R4";
    frame(30, 4'b0000);
    chk("R4", "oversize word", headStatus, 16'h4800 | MAX_LEN);
    discard();
    frame(MAX_LEN, 4'b0000);
    chk("R4", "exact max not oversize", headStatus, MAX_LEN);
    discard();

    // R6: discard on open head ignored
    phase = "R6";
    frmStart = 1; cyc(); frmStart = 0; frmByte = 1; cyc(); cyc(); frmByte = 0;
    discardCmd = 1; cyc(); discardCmd = 0;
    chk("R6", "open head kept", headStatus, 16'h8002);
    frmEnd = 1; frmCode = 4'b0000; cyc(); idle();
    discard();

    // R5: fill storage
    phase = "R5";
    for (int k = 0; k < DEPTH; k++) frame(k + 1, 4'(k));
    chk("R5", "overrun flag", statusOverrun, 1);
    frmStart = 1; cyc(); frmStart = 0;
    chk("R5", "refused not receiving", rxReceiving, 0);
    frame(5, 4'b1100);
    frmByte = 1; frmEnd = 1; cyc(); idle();
    chk("R5", "head unchanged", headStatus, {1'b0, 4'd0, 11'd1});
    chk("R5", "no completion", rxCompleteEvt, 0);
    discard();
    chk("R5", "flag clears", statusOverrun, 0);

    // R10: arrival order
    phase = "R10";
    chk("R10", "second entry", headStatus, {1'b0, 4'd1, 11'd2});
    for (int k = 2; k < DEPTH; k++) begin
      discard();
      chk("R10", "entry order", headStatus, {1'b0, 4'(k), 11'(k + 1)});
    end
    discard();
    chk("R10", "drained", headStatus, 16'h8000);

    // R9: reset mid-frame with entries held
    phase = "R9";
    frame(3, 4'b0000);
    frmStart = 1; cyc(); frmStart = 0; frmByte = 1; cyc(); cyc();
    rxReset = 1; cyc(); idle();
    chk("R9", "reset empties", headStatus, 16'h8000);
    chk("R9", "reset closes frame", rxReceiving, 0);
    frmByte = 1; frmEnd = 1; cyc(); idle();
    chk("R9", "stale end ignored", headStatus, 16'h8000);
    repeat (2) cyc();

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule